// File: doc/BRIEF.md
# 64-bit Down-Counting Event Timer

This block is a bus-mapped timer built around a 64-bit down counter. Software programs a 64-bit start value through two 32-bit load registers, then starts the counter by setting the run bit of the control register. Each cycle in which the `tick` input is high moves the counter down by one. When a tick arrives while the counter already shows zero, the block records an expiry in a sticky status bit. Software clears that bit by writing a one to it.

The control register selects one of two modes. In periodic mode the counter refills itself from the load registers on every expiry, so a load value of N gives one expiry every N+1 ticks. In single-count mode the counter stops at zero after the first expiry and stays there until the run bit is cleared and set again. A separate unmask bit passes the status bit to the `irq` output. With both load halves at all ones and the interrupt masked, the block serves as a continuous 64-bit time base: software inverts the value it reads to get an up-counting clock. Both value registers read the same live counter, so a reader that takes high, low, high in turn can detect a borrow between the halves.

Top module: `cdt64_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: The load low half (offset 0x00) and load high half (0x04) read back what was last written. The control register (0x10) holds run in bit 0, single-count mode in bit 1 and interrupt unmask in bit 2, and its bits 31..3 always read 0.
- R3: A control write that sets bit 0 while the run bit is 0 copies the full 64-bit load value into the counter on that clock edge. A control write with bit 0 set while already running does not refill the counter.
- R4: While running, the counter drops by exactly one on each cycle with `tick` high. It holds its value on cycles with `tick` low and whenever the run bit is 0.
- R5: In periodic mode (control bit 1 = 0), a tick at zero sets the status bit and refills the counter from the load registers. After the counter starts from N, the first expiry comes on the (N+1)-th tick, and later expiries follow every N+1 ticks.
- R6: In single-count mode (control bit 1 = 1), a tick at zero sets the status bit once. The counter then stays at zero and sets no further status until it is restarted by clearing and setting the run bit.
- R7: The status register (0x18) shows the expiry flag in bit 0. Writing a word with bit 0 = 1 clears it. Writing a word with bit 0 = 0 has no effect.
- R8: When an expiry and a clearing write to 0x18 fall in the same cycle, the status bit ends up set.
- R9: `irq` is high exactly when the status bit and the unmask bit (control bit 2) are both 1. The status bit still sets while the interrupt is masked.
- R10: The value registers show the low (0x08) and high (0x0C) halves of one live 64-bit counter. A borrow out of the low half shows in the high half on the same edge, and a counter started from all ones keeps running down across the full 64 bits.
- R11: Reads from any other offset, including misaligned ones, return 0. Writes to 0x08, 0x0C or unmapped offsets change nothing.
- R12: No expiry is recorded while the run bit is 0, even when the counter shows zero and ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe, one per timer period |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Status bit gated by the unmask bit |

## Verification
The expiry that sets the status bit and the software write that clears it can land on the same clock edge. The bench provokes this collision by watching its own model: it drives the clearing write in the exact cycle in which the model's counter shows zero with a tick pending. It then reads 0x18 and expects 1. A second collision is a control write that sets the run bit while ticks keep arriving. That write must refill the counter only when the block was stopped. The bench checks this by reading the value registers before and after a repeated start.

// File: rtl/cdt64_pkg.sv
package cdt64_pkg;

  localparam logic [7:0] OFF_LOAD_LO = 8'h00;
  localparam logic [7:0] OFF_LOAD_HI = 8'h04;
  localparam logic [7:0] OFF_CUR_LO  = 8'h08;
  localparam logic [7:0] OFF_CUR_HI  = 8'h0C;
  localparam logic [7:0] OFF_CTRL    = 8'h10;
  localparam logic [7:0] OFF_STAT    = 8'h18;

  typedef struct packed {
    logic unmask;
    logic single;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD_LO,
    SEL_LOAD_HI,
    SEL_CUR_LO,
    SEL_CUR_HI,
    SEL_CTRL,
    SEL_STAT
  } sel_e;

endpackage

// File: rtl/cdt64_decode.sv
module cdt64_decode
  import cdt64_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);

  function automatic sel_e decode_offset(input logic [ADDR_W-1:0] a);
    sel_e s;
    s = SEL_NONE;
    if (a == ADDR_W'(OFF_LOAD_LO)) s = SEL_LOAD_LO;
    if (a == ADDR_W'(OFF_LOAD_HI)) s = SEL_LOAD_HI;
    if (a == ADDR_W'(OFF_CUR_LO))  s = SEL_CUR_LO;
    if (a == ADDR_W'(OFF_CUR_HI))  s = SEL_CUR_HI;
    if (a == ADDR_W'(OFF_CTRL))    s = SEL_CTRL;
    if (a == ADDR_W'(OFF_STAT))    s = SEL_STAT;
    return s;
  endfunction

  assign sel = decode_offset(addr);

endmodule

// File: rtl/cdt64_regs.sv
module cdt64_regs
  import cdt64_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  load_val,
  output ctrl_t             ctrl,
  output logic              load_evt,
  output logic              clr_wr
);

  ctrl_t ctrl_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam sel_e HALF_SEL = (h == 0) ? SEL_LOAD_LO : SEL_LOAD_HI;
    logic [DATA_W-1:0] half_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        half_q <= '0;
      end else if (we && sel == HALF_SEL) begin
        half_q <= wdata;
      end
    end
    assign load_val[h*DATA_W +: DATA_W] = half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we && sel == SEL_CTRL) begin
      ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  function automatic logic starts_run(input logic wr, input sel_e s,
                                      input logic new_run, input logic old_run);
    return wr && (s == SEL_CTRL) && new_run && !old_run;
  endfunction

  assign ctrl     = ctrl_q;
  assign load_evt = starts_run(we, sel, wdata[0], ctrl_q.run);
  assign clr_wr   = we && (sel == SEL_STAT) && wdata[0];

endmodule

// File: rtl/cdt64_counter.sv
module cdt64_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             single,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             at_zero;
  logic             step;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign at_zero = (cnt_q == '0);
  assign step    = run && tick;
  assign expire  = step && at_zero && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_evt) begin
      cnt_q  <= load_val;
      done_q <= 1'b0;
    end else if (step) begin
      if (!at_zero) begin
        cnt_q <= count_down(cnt_q);
      end else if (!done_q) begin
        if (single) begin
          done_q <= 1'b1;
        end else begin
          cnt_q <= load_val;
        end
      end
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cdt64_status.sv
module cdt64_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_wr,
  input  logic unmask,
  output logic status,
  output logic irq
);

  logic status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (expire) begin
      status_q <= 1'b1;
    end else if (clr_wr) begin
      status_q <= 1'b0;
    end
  end

  assign status = status_q;
  assign irq    = status_q & unmask;

endmodule

// File: rtl/cdt64_timer.sv
module cdt64_timer
  import cdt64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;

  sel_e             sel;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             load_evt;
  logic             clr_wr;
  logic             expire;
  logic             status;
  logic             ctl_run;
  logic             ctl_single;
  logic             ctl_unmask;

  cdt64_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  cdt64_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .sel      (sel),
    .wdata    (bus_wdata),
    .load_val (load_val),
    .ctrl     (ctrl),
    .load_evt (load_evt),
    .clr_wr   (clr_wr)
  );

  assign ctl_run    = ctrl.run;
  assign ctl_single = ctrl.single;
  assign ctl_unmask = ctrl.unmask;

  cdt64_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (ctl_run),
    .single   (ctl_single),
    .load_evt (load_evt),
    .load_val (load_val),
    .cnt      (cnt),
    .expire   (expire)
  );

  cdt64_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .clr_wr (clr_wr),
    .unmask (ctl_unmask),
    .status (status),
    .irq    (irq)
  );

  always_comb begin
    case (sel)
      SEL_LOAD_LO: bus_rdata = load_val[DATA_W-1:0];
      SEL_LOAD_HI: bus_rdata = load_val[CNT_W-1:DATA_W];
      SEL_CUR_LO:  bus_rdata = cnt[DATA_W-1:0];
      SEL_CUR_HI:  bus_rdata = cnt[CNT_W-1:DATA_W];
      SEL_CTRL:    bus_rdata = DATA_W'(ctrl);
      SEL_STAT:    bus_rdata = DATA_W'(status);
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cdt64_timer_chk.sv
module cdt64_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             single,
  input logic             unmask,
  input logic             load_evt,
  input logic             clr_wr,
  input logic             expire,
  input logic             status,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val
);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt == $past(load_val)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt != '0 && !load_evt) |=> cnt == $past(cnt) - CNT_W'(1)); // R4

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_evt) |=> $stable(cnt)); // R4

  AST_PERIODIC_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !single) |=> cnt == $past(load_val)); // R5

  AST_SINGLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && single && cnt == '0 && !load_evt) |=> cnt == '0); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !status); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status); // R8

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !unmask |-> !irq); // R9

  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !expire); // R12

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !status) |=> !status); // R7

endmodule

bind cdt64_timer cdt64_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .run      (ctl_run),
  .single   (ctl_single),
  .unmask   (ctl_unmask),
  .load_evt (load_evt),
  .clr_wr   (clr_wr),
  .expire   (expire),
  .status   (status),
  .irq      (irq),
  .cnt      (cnt),
  .load_val (load_val)
);

// File: tb/test_cdt64_timer.sv
module test_cdt64_timer;

  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  always #5 clk = ~clk;

  cdt64_timer #(.DATA_W(DW), .ADDR_W(AW)) i_cdt64_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  int    checks = 0;
  int    fails = 0;
  int    ncyc = 0;
  string cur_req = "R1";
  logic  s_irq = 1'b0;

  // behavioural reference model
  logic [63:0] m_load = '0;
  logic [63:0] m_cnt = '0;
  logic m_run = 1'b0, m_single = 1'b0, m_unmask = 1'b0, m_st = 1'b0, m_done = 1'b0;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_load[31:0];
      5'h04:   return m_load[63:32];
      5'h08:   return m_cnt[31:0];
      5'h0C:   return m_cnt[63:32];
      5'h10:   return {29'd0, m_unmask, m_single, m_run};
      5'h18:   return {31'd0, m_st};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic starting;
    logic fired;
    if (!rst_n) begin
      m_load = '0; m_cnt = '0; m_run = 0; m_single = 0; m_unmask = 0; m_st = 0; m_done = 0;
    end else begin
      starting = we && addr == 5'h10 && wdata[0] && !m_run;
      fired = !starting && m_run && tick && m_cnt == 0 && !m_done;
      if (starting) begin
        m_cnt = m_load; m_done = 0;
      end else if (m_run && tick) begin
        if (m_cnt != 0) m_cnt = m_cnt - 1;
        else if (!m_done) begin
          if (m_single) m_done = 1;
          else m_cnt = m_load;
        end
      end
      if (fired) m_st = 1;
      else if (we && addr == 5'h18 && wdata[0]) m_st = 0;
      if (we) begin
        if (addr == 5'h00) m_load[31:0] = wdata;
        if (addr == 5'h04) m_load[63:32] = wdata;
        if (addr == 5'h10) {m_unmask, m_single, m_run} = wdata[2:0];
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_now();
    s_irq = irq;
    if (rst_n) begin
      check(cur_req, {63'd0, irq}, {63'd0, m_st & m_unmask}, "irq vs model");
      check(cur_req, {32'd0, rdata}, {32'd0, m_read(addr)}, "rdata vs model");
    end
  endtask

  task automatic cycle(input logic w, input logic [4:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    ncyc++;
    compare_now();
    we = w; addr = a; wdata = d; tick = t;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    cycle(1'b0, a, 32'd0, 1'b0);
    #1 v = rdata;
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog R1: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int e, t1, t2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    foreach (m_load[i]) if (i < 6) begin
      rd(5'(i == 5 ? 8'h18 : i * 4), v);
      check("R1", {32'd0, v}, 64'd0, "register after reset");
    end
    check("R1", {63'd0, irq}, 64'd0, "irq after reset");

    // R2 readback
    cur_req = "R2";
    cycle(1, 5'h00, 32'hA5A5_0001, 0);
    cycle(1, 5'h04, 32'h0F0F_1234, 0);
    rd(5'h00, v); check("R2", {32'd0, v}, 64'hA5A5_0001, "load low");
    rd(5'h04, v); check("R2", {32'd0, v}, 64'h0F0F_1234, "load high");
    cycle(1, 5'h10, 32'hFFFF_FFF8, 0);
    rd(5'h10, v); check("R2", {32'd0, v}, 64'd0, "ctrl upper bits");
    cycle(1, 5'h10, 32'h6, 0);
    rd(5'h10, v); check("R2", {32'd0, v}, 64'h6, "ctrl field");
    cycle(1, 5'h10, 32'h0, 0);

    // R5 periodic timing, N = 3
    cur_req = "R5";
    cycle(1, 5'h00, 32'd3, 1);
    cycle(1, 5'h04, 32'd0, 1);
    cycle(1, 5'h10, 32'h5, 1);
    e = ncyc; t1 = 0; t2 = 0;
    for (int k = 0; k < 20; k++) begin
      cycle(0, 5'h08, 0, 1);
      if (s_irq) begin t1 = ncyc; break; end
    end
    check("R5", 64'(t1 - e), 64'd5, "first expiry after N+1 ticks");
    cycle(1, 5'h18, 32'd1, 1);
    for (int k = 0; k < 20; k++) begin
      cycle(0, 5'h08, 0, 1);
      if (s_irq) begin t2 = ncyc; break; end
    end
    check("R5", 64'(t2 - t1), 64'd4, "period of N+1 ticks");

    // R8 set beats clear in the same cycle
    cur_req = "R8";
    cycle(1, 5'h18, 32'd1, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      ncyc++;
      compare_now();
      if (m_cnt == 0 && m_run) begin
        we = 1; addr = 5'h18; wdata = 32'd1; tick = 1;
        break;
      end
      we = 0; addr = 5'h18; wdata = 32'd0; tick = 1;
    end
    rd(5'h18, v); check("R8", {32'd0, v}, 64'd1, "status after colliding clear");

    // R7 write-one-to-clear
    cur_req = "R7";
    cycle(1, 5'h18, 32'd0, 0);
    rd(5'h18, v); check("R7", {32'd0, v}, 64'd1, "write 0 keeps status");
    cycle(1, 5'h18, 32'hFFFF_FFFE, 0);
    rd(5'h18, v); check("R7", {32'd0, v}, 64'd1, "bit0 clear keeps status");
    cycle(1, 5'h18, 32'd1, 0);
    rd(5'h18, v); check("R7", {32'd0, v}, 64'd0, "write 1 clears status");

    // R9 masking
    cur_req = "R9";
    cycle(1, 5'h10, 32'h1, 0);
    repeat (6) cycle(0, 5'h18, 0, 1);
    rd(5'h18, v); check("R9", {32'd0, v}, 64'd1, "status sets while masked");
    check("R9", {63'd0, irq}, 64'd0, "irq held low while masked");
    cycle(1, 5'h10, 32'h5, 0);
    rd(5'h18, v); check("R9", {63'd0, irq}, 64'd1, "irq after unmask");
    cycle(1, 5'h18, 32'd1, 0);

    // R3 start loads, restart does not
    cur_req = "R3";
    cycle(1, 5'h10, 32'h0, 0);
    cycle(1, 5'h00, 32'd100, 0);
    cycle(1, 5'h04, 32'd0, 0);
    cycle(1, 5'h10, 32'h1, 0);
    rd(5'h08, v); check("R3", {32'd0, v}, 64'd100, "counter loaded on start");
    repeat (5) cycle(0, 5'h08, 0, 1);
    rd(5'h08, v); check("R4", {32'd0, v}, 64'd95, "five ticks counted");
    cycle(1, 5'h10, 32'h1, 0);
    rd(5'h08, v); check("R3", {32'd0, v}, 64'd95, "no refill while running");

    // R4 hold
    cur_req = "R4";
    repeat (4) cycle(0, 5'h08, 0, 0);
    rd(5'h08, v); check("R4", {32'd0, v}, 64'd95, "hold with tick low");
    cycle(1, 5'h10, 32'h0, 0);
    repeat (5) cycle(0, 5'h08, 0, 1);
    rd(5'h08, v); check("R4", {32'd0, v}, 64'd95, "hold while stopped");

    // R12 no expiry while stopped
    cur_req = "R12";
    cycle(1, 5'h00, 32'd0, 0);
    cycle(1, 5'h10, 32'h3, 0);
    cycle(1, 5'h10, 32'h0, 0);
    repeat (6) cycle(0, 5'h18, 0, 1);
    rd(5'h18, v); check("R12", {32'd0, v}, 64'd0, "no status while stopped at zero");

    // R6 single count
    cur_req = "R6";
    cycle(1, 5'h00, 32'd2, 0);
    cycle(1, 5'h10, 32'h7, 0);
    repeat (3) cycle(0, 5'h08, 0, 1);
    rd(5'h18, v); check("R6", {32'd0, v}, 64'd1, "single expiry");
    rd(5'h08, v); check("R6", {32'd0, v}, 64'd0, "parked at zero");
    cycle(1, 5'h18, 32'd1, 0);
    repeat (10) cycle(0, 5'h08, 0, 1);
    rd(5'h18, v); check("R6", {32'd0, v}, 64'd0, "no second expiry");
    rd(5'h08, v); check("R6", {32'd0, v}, 64'd0, "still zero");
    cycle(1, 5'h10, 32'h0, 0);
    cycle(1, 5'h10, 32'h7, 0);
    rd(5'h08, v); check("R6", {32'd0, v}, 64'd2, "restart reloads");

    // R10 halves of one counter
    cur_req = "R10";
    cycle(1, 5'h10, 32'h0, 0);
    cycle(1, 5'h00, 32'd0, 0);
    cycle(1, 5'h04, 32'd1, 0);
    cycle(1, 5'h10, 32'h3, 0);
    rd(5'h08, v); check("R10", {32'd0, v}, 64'd0, "low before borrow");
    rd(5'h0C, v); check("R10", {32'd0, v}, 64'd1, "high before borrow");
    cycle(0, 5'h08, 0, 1);
    rd(5'h08, v); check("R10", {32'd0, v}, 64'hFFFF_FFFF, "low after borrow");
    rd(5'h0C, v); check("R10", {32'd0, v}, 64'd0, "high after borrow");
    cycle(1, 5'h10, 32'h0, 0);
    cycle(1, 5'h00, 32'hFFFF_FFFF, 0);
    cycle(1, 5'h04, 32'hFFFF_FFFF, 0);
    cycle(1, 5'h10, 32'h1, 0);
    repeat (7) cycle(0, 5'h08, 0, 1);
    rd(5'h0C, v); check("R10", {32'd0, v}, 64'hFFFF_FFFF, "free-running high");
    rd(5'h08, v); check("R10", {32'd0, v}, 64'hFFFF_FFF8, "free-running low");

    // R11 unmapped and read-only offsets
    cur_req = "R11";
    rd(5'h14, v); check("R11", {32'd0, v}, 64'd0, "offset 0x14");
    rd(5'h1C, v); check("R11", {32'd0, v}, 64'd0, "offset 0x1C");
    rd(5'h02, v); check("R11", {32'd0, v}, 64'd0, "misaligned 0x02");
    cycle(1, 5'h08, 32'h1234, 0);
    cycle(1, 5'h0C, 32'h5678, 0);
    rd(5'h08, v); check("R11", {32'd0, v}, 64'hFFFF_FFF8, "value low unwritable");
    rd(5'h0C, v); check("R11", {32'd0, v}, 64'hFFFF_FFFF, "value high unwritable");
    cycle(1, 5'h14, 32'h7, 0);
    rd(5'h10, v); check("R11", {32'd0, v}, 64'h1, "ctrl untouched by 0x14");

    cycle(0, 5'h00, 0, 0);
    report();
    $finish;
  end

endmodule